// File: doc/BRIEF.md
# Sectioned Register Address Sequencer

This block produces the byte address for multi-byte reads and page writes into a 64-location control register space. The space holds five sections: two 8-byte alarm sections at 0x00–0x07 and 0x08–0x0F, a 1-byte control section at 0x10, an 8-byte time section at 0x30–0x37 and a 1-byte status section at 0x3F. Every other address is reserved. A transaction starts either at a supplied address or at the address kept from the previous transaction, which gives a current-address read. Each transferred byte moves the address forward. The address wraps inside the section where the transaction began and never crosses into a neighbouring section.

The block also decides whether a write may land at the current address. Writes to the status byte are always allowed. Writes to any other section need both enable flags: the write-enable latch, set first, and then the register-write-enable bit. A continued access to the status byte, or any access to a reserved address, raises a terminate flag that ends the operation. The flag stays set until the next start. The register contents are stored outside this block.

Top module: `regsec_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0x00, `term_o` is 0 and `wr_ok_o` is 0.
- R2: A start pulse with `load_i`=1 sets `addr_o` to `start_addr_i` in the next cycle. With `load_i`=0 the retained address is used unchanged. `rw_i`=1 marks a write and 0 marks a read.
- R3: An advance in an 8-byte section adds one to address bits [2:0] and keeps bits [5:3], so 0x07 goes to 0x00, 0x0F to 0x08 and 0x37 to 0x30. An advance at the control byte 0x10 stays at 0x10.
- R4: After a stop, the address retained is the last accessed address plus one, wrapped inside its section. A later start with `load_i`=0 continues from that address.
- R5: An advance while the address is 0x3F sets `term_o` and leaves the address at 0x3F.
- R6: A start at a reserved address sets `term_o` in the next cycle. While `term_o` is set, advances do not change `addr_o`.
- R7: Outside the status section, `wr_ok_o` is 1 only during an active, unterminated write with `wel_i`=1 and `rwel_i`=1.
- R8: At the status byte 0x3F, `wr_ok_o` is 1 during an active, unterminated write whatever the values of `wel_i` and `rwel_i`.
- R9: `wr_ok_o` is 0 during reads, when no transaction is active and while `term_o` is set.
- R10: A start takes priority over an advance or a stop in the same cycle, and the advance or stop is ignored. An advance together with a stop applies the advance and then ends the transaction.
- R11: A start at a non-reserved address clears `term_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction |
| load_i | input | 1 | 1: take start_addr_i, 0: keep the retained address |
| start_addr_i | input | 6 | Start address |
| rw_i | input | 1 | 1 = write, 0 = read |
| adv_i | input | 1 | One byte transferred |
| stop_i | input | 1 | End of transaction |
| wel_i | input | 1 | Write-enable latch state |
| rwel_i | input | 1 | Register-write-enable state |
| addr_o | output | 6 | Current address |
| wr_ok_o | output | 1 | Write permitted at the current address |
| term_o | output | 1 | Operation terminated |

## Verification
A start can arrive in the same cycle as an advance or a stop, and an advance can coincide with a stop. The bench drives these collisions directly at section ends, such as an advance with a stop at 0x37, and also produces them at random. It judges each collision by the address, terminate flag and write permission in the following cycle. The priority, the wrap and the retained address are predicted by a bench model built from the requirements.

// File: rtl/regsec_pkg.sv
package regsec_pkg;
  localparam int ADDR_W  = 6;
  localparam int NUM_SEC = 5;
  localparam int SEC_W   = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEC_W-1:0]  sec_t;

  // Section order: alarm 0, alarm 1, control, time, status
  localparam addr_t SEC_BASE   [NUM_SEC] = '{6'h00, 6'h08, 6'h10, 6'h30, 6'h3F};
  localparam int    SEC_LOG2   [NUM_SEC] = '{3, 3, 0, 3, 0};
  localparam logic  SEC_SINGLE [NUM_SEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic  SEC_GUARD  [NUM_SEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam sec_t  SEC_RSV = sec_t'(NUM_SEC);

  function automatic addr_t sec_mask(int lg);
    return addr_t'({ADDR_W{1'b1}} << lg);
  endfunction
endpackage

// File: rtl/regsec_rst_sync.sv
module regsec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/regsec_decode.sv
module regsec_decode
  import regsec_pkg::*;
(
  input  addr_t addr_i,
  output sec_t  sec_o
);
  logic [NUM_SEC-1:0] hit;

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    localparam addr_t MASK = sec_mask(SEC_LOG2[g]);
    assign hit[g] = ((addr_i & MASK) == (SEC_BASE[g] & MASK));
  end

  always_comb begin
    sec_o = SEC_RSV;
    for (int i = NUM_SEC - 1; i >= 0; i--) begin
      if (hit[i]) sec_o = sec_t'(i);
    end
  end
endmodule

// File: rtl/regsec_step.sv
module regsec_step
  import regsec_pkg::*;
(
  input  addr_t addr_i,
  input  sec_t  sec_i,
  output addr_t next_o,
  output logic  single_o
);
  addr_t cand [NUM_SEC];
  addr_t inc;

  assign inc = addr_i + addr_t'(1);

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_wrap
    localparam addr_t MASK = sec_mask(SEC_LOG2[g]);
    assign cand[g] = (addr_i & MASK) | (inc & ~MASK);
  end

  always_comb begin
    next_o   = addr_i;
    single_o = 1'b1;
    for (int i = 0; i < NUM_SEC; i++) begin
      if (sec_i == sec_t'(i)) begin
        next_o   = cand[i];
        single_o = SEC_SINGLE[i];
      end
    end
  end
endmodule

// File: rtl/regsec_wgate.sv
module regsec_wgate
  import regsec_pkg::*;
(
  input  sec_t sec_i,
  input  logic act_i,
  input  logic wr_i,
  input  logic term_i,
  input  logic wel_i,
  input  logic rwel_i,
  output logic wr_ok_o
);
  logic guard;

  always_comb begin
    guard = 1'b1;
    for (int i = 0; i < NUM_SEC; i++) begin
      if (sec_i == sec_t'(i)) guard = SEC_GUARD[i];
    end
  end

  assign wr_ok_o = act_i & wr_i & ~term_i & (~guard | (wel_i & rwel_i));
endmodule

// File: rtl/regsec_addr_seq.sv
module regsec_addr_seq
  import regsec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        load_i,
  input  logic [5:0]  start_addr_i,
  input  logic        rw_i,
  input  logic        adv_i,
  input  logic        stop_i,
  input  logic        wel_i,
  input  logic        rwel_i,
  output logic [5:0]  addr_o,
  output logic        wr_ok_o,
  output logic        term_o
);
  logic  rst_int_n;
  addr_t addr_q, addr_n, cand_addr, step_addr;
  sec_t  sec_q, sec_n, cand_sec;
  logic  act_q, act_n, wr_q, wr_n, term_q, term_n;
  logic  single, en;

  regsec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  assign cand_addr = load_i ? start_addr_i : addr_q;

  regsec_decode u_dec (.addr_i(cand_addr), .sec_o(cand_sec));

  regsec_step u_step (
    .addr_i(addr_q), .sec_i(sec_q), .next_o(step_addr), .single_o(single)
  );

  regsec_wgate u_gate (
    .sec_i(sec_q), .act_i(act_q), .wr_i(wr_q), .term_i(term_q),
    .wel_i(wel_i), .rwel_i(rwel_i), .wr_ok_o(wr_ok_o)
  );

  assign en = start_i | (act_q & (adv_i | stop_i));

  always_comb begin
    addr_n = addr_q;
    sec_n  = sec_q;
    act_n  = act_q;
    wr_n   = wr_q;
    term_n = term_q;
    if (start_i) begin
      addr_n = cand_addr;
      sec_n  = cand_sec;
      act_n  = 1'b1;
      wr_n   = rw_i;
      term_n = (cand_sec == SEC_RSV);
    end else if (act_q) begin
      if (adv_i && !term_q) begin
        if (single) term_n = 1'b1;
        else        addr_n = step_addr;
      end
      if (stop_i) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      sec_q  <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      term_q <= 1'b0;
    end else if (en) begin
      addr_q <= addr_n;
      sec_q  <= sec_n;
      act_q  <= act_n;
      wr_q   <= wr_n;
      term_q <= term_n;
    end
  end

  assign addr_o = addr_q;
  assign term_o = term_q;
endmodule

// File: rtl/regsec_addr_seq_chk.sv
module regsec_addr_seq_chk
  import regsec_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       load_i,
  input logic [5:0] start_addr_i,
  input logic       adv_i,
  input logic       wel_i,
  input logic       rwel_i,
  input logic [5:0] addr_o,
  input logic       wr_ok_o,
  input logic       term_o,
  input logic       act_q,
  input logic [2:0] sec_q
);
  logic rsv_start;
  assign rsv_start = !((start_addr_i <= 6'h10) ||
                       (start_addr_i >= 6'h30 && start_addr_i <= 6'h37) ||
                       (start_addr_i == 6'h3F));

  // R3: advance in an 8-byte section stays in it and steps by one
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !term_o && adv_i && !start_i && (sec_q == 3'd0 || sec_q == 3'd1 || sec_q == 3'd3))
    |=> (addr_o[5:3] == $past(addr_o[5:3])) && (addr_o[2:0] == $past(addr_o[2:0]) + 3'd1));

  // R5
  assert_status_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !term_o && adv_i && !start_i && addr_o == 6'h3F) |=> (term_o && addr_o == 6'h3F));

  // R6
  assert_rsv_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && load_i && rsv_start) |=> term_o);

  assert_term_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_o && !start_i) |=> $stable(addr_o));

  // R7
  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_o && addr_o != 6'h3F) |-> (wel_i && rwel_i));

  // R9
  assert_no_wr_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> !wr_ok_o);

  // R10
  assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && load_i) |=> (addr_o == $past(start_addr_i)));
endmodule

bind regsec_addr_seq regsec_addr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
  .start_addr_i(start_addr_i), .adv_i(adv_i), .wel_i(wel_i), .rwel_i(rwel_i),
  .addr_o(addr_o), .wr_ok_o(wr_ok_o), .term_o(term_o),
  .act_q(act_q), .sec_q(sec_q)
);

// File: tb/regsec_addr_seq_tb.sv
module regsec_addr_seq_tb;
  logic clk, rst_n;
  logic start_i, load_i, rw_i, adv_i, stop_i, wel_i, rwel_i;
  logic [5:0] start_addr_i, addr_o;
  logic wr_ok_o, term_o;

  int checks, errors;
  logic [5:0] m_addr;
  int m_sec;
  logic m_act, m_wr, m_term;

  regsec_addr_seq u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sec_of(logic [5:0] a);
    if (a <= 6'h07) return 0;
    if (a <= 6'h0F) return 1;
    if (a == 6'h10) return 2;
    if (a >= 6'h30 && a <= 6'h37) return 3;
    if (a == 6'h3F) return 4;
    return 5;
  endfunction

  function automatic logic [5:0] step_of(logic [5:0] a, int s);
    if (s == 0 || s == 1 || s == 3) return {a[5:3], a[2:0] + 3'd1};
    return a;
  endfunction

  function automatic logic exp_wr_ok(logic w, logic rw);
    return m_act && m_wr && !m_term && (m_sec == 4 || (w && rw));
  endfunction

  task automatic check(string tag);
    logic ew;
    ew = exp_wr_ok(wel_i, rwel_i);
    checks++;
    if (addr_o !== m_addr || term_o !== m_term || wr_ok_o !== ew) begin
      errors++;
      $display("FAIL %s addr=%h term=%b wr_ok=%b expected addr=%h term=%b wr_ok=%b",
               tag, addr_o, term_o, wr_ok_o, m_addr, m_term, ew);
    end
  endtask

  task automatic op(logic st, logic ld, logic [5:0] a, logic rw, logic ad, logic sp,
                    logic w, logic r, string tag);
    logic [5:0] ca;
    @(negedge clk);
    start_i = st; load_i = ld; start_addr_i = a; rw_i = rw;
    adv_i = ad; stop_i = sp; wel_i = w; rwel_i = r;
    if (st) begin
      ca = ld ? a : m_addr;
      m_addr = ca; m_sec = sec_of(ca); m_act = 1'b1; m_wr = rw; m_term = (m_sec == 5);
    end else if (m_act) begin
      if (ad && !m_term) begin
        if (m_sec == 4) m_term = 1'b1;
        else m_addr = step_of(m_addr, m_sec);
      end
      if (sp) m_act = 1'b0;
    end
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    checks = 0; errors = 0;
    start_i = 0; load_i = 0; start_addr_i = 0; rw_i = 0;
    adv_i = 0; stop_i = 0; wel_i = 0; rwel_i = 0;
    m_addr = 0; m_sec = 0; m_act = 0; m_wr = 0; m_term = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    op(1, 1, 6'h05, 1, 0, 0, 1, 1, "R2");
    op(0, 0, 0, 0, 1, 0, 1, 1, "R3");
    op(0, 0, 0, 0, 1, 0, 1, 1, "R3");
    op(0, 0, 0, 0, 1, 0, 1, 1, "R3");          // 0x07 -> 0x00
    op(0, 0, 0, 0, 0, 0, 1, 0, "R7");          // rwel low blocks write
    op(0, 0, 0, 0, 0, 0, 0, 1, "R7");
    op(0, 0, 0, 0, 0, 1, 1, 1, "R9");          // idle
    op(1, 0, 6'h2A, 0, 0, 0, 1, 1, "R4");      // current-address read at 0x00
    op(0, 0, 0, 0, 1, 1, 1, 1, "R4");          // retained 0x01
    op(1, 0, 6'h00, 0, 0, 0, 1, 1, "R4");
    op(1, 1, 6'h0F, 0, 1, 0, 1, 1, "R10");     // start beats advance
    op(0, 0, 0, 0, 1, 0, 1, 1, "R3");          // 0x0F -> 0x08
    op(1, 1, 6'h10, 1, 0, 0, 1, 1, "R7");
    op(0, 0, 0, 0, 1, 0, 1, 1, "R3");          // control stays
    op(1, 1, 6'h37, 0, 0, 0, 1, 1, "R2");
    op(0, 0, 0, 0, 1, 1, 1, 1, "R10");         // advance + stop -> 0x30, idle
    op(1, 0, 0, 1, 0, 0, 1, 1, "R4");
    op(1, 1, 6'h3F, 1, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 0, 1, 0, 0, 0, "R5");
    op(1, 1, 6'h20, 1, 0, 0, 1, 1, "R6");
    op(0, 0, 0, 0, 1, 0, 1, 1, "R6");
    op(1, 1, 6'h33, 1, 0, 1, 1, 1, "R11");     // start beats stop, term cleared
    op(1, 1, 6'h34, 1, 1, 1, 1, 1, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ra;
      int pick;
      pick = $urandom_range(0, 9);
      case ($urandom_range(0, 5))
        0: ra = 6'h3F;
        1: ra = 6'h10;
        2: ra = 6'(6'h30 + $urandom_range(0, 7));
        default: ra = 6'($urandom_range(0, 63));
      endcase
      op(pick < 2, 1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)),
         pick >= 1 && pick < 8, pick == 8 || pick == 1,
         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R3/R7/R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule